// File: doc/BRIEF.md
# Parallel Test-Mode Compare Path for a x4 DRAM Data Path

This block sits between the DQ pins of a by-four DRAM model and its cell array. The array is split into eight one-bit sections, arranged as two groups of four. In normal operation the lowest column address bit picks one group. That group's four sections then carry the four DQ lanes directly, so writes fan out lane by lane and reads return that group's four bits.

When the test flag is raised, the block compresses the array for fast screening. A write stores the value on DQ lane 0 into all eight sections at once, and the other lanes are ignored. A read compares the eight section bits: if they agree, all four DQ outputs go high; if any one disagrees, all four go low. In this mode the group-select column bit has no effect, so the part behaves as a half-size memory. The read and write strobes are independent, so read, write, read-modify-write and page sequences work in both modes.

Writes are combinational: the section enables and data follow the strobe within the same cycle. Read results are registered: the DQ outputs take the new value on the clock edge where the read strobe is high, and they hold it otherwise. Test-mode entry decoding and the array itself belong to neighbouring blocks.

Top module: `tmc_compare_path`

## Requirements
- R1: With test_mode=1 and wr_strobe=1, all eight bits of sec_we are 1, and every bit of sec_wd equals dq_in[0] in the same cycle.
- R2: With test_mode=1, the value of dq_in[3:1] has no effect on sec_wd or sec_we.
- R3: With test_mode=1 and rd_strobe=1, if sec_rd is 8'h00 or 8'hFF, dq_out is 4'hF after the next rising clock edge.
- R4: With test_mode=1 and rd_strobe=1, if sec_rd holds both zeros and ones, dq_out is 4'h0 after the next rising clock edge.
- R5: With test_mode=1, col_lsb has no effect on sec_we or on the read result.
- R6: With test_mode=0 and wr_strobe=1, sec_we is 4'hF shifted left by 4*col_lsb (sections 0-3 for col_lsb=0, sections 4-7 for col_lsb=1), and sec_wd[4*g+k] equals dq_in[k] for both groups g.
- R7: With test_mode=0 and rd_strobe=1, dq_out after the next rising edge equals sec_rd[4*col_lsb +: 4].
- R8: With wr_strobe=0, sec_we is all zeros in either mode.
- R9: With rd_strobe=0, dq_out keeps its value across the clock edge.
- R10: While rst_n is low, dq_out is 4'h0.
- R11: When rd_strobe and wr_strobe are both high in the same cycle, the read result and the write enables each follow their own rules (read-modify-write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the read result register |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode | input | 1 | 1 selects compressed parallel test operation |
| wr_strobe | input | 1 | Write request for this cycle |
| rd_strobe | input | 1 | Read request, sampled at the rising edge |
| col_lsb | input | $clog2(GRP) | Low column address bits that select the section group |
| dq_in | input | DQ_W | Write data from the DQ pins |
| sec_rd | input | DQ_W*GRP | Read bits from the eight array sections |
| sec_we | output | DQ_W*GRP | Per-section write enables |
| sec_wd | output | DQ_W*GRP | Per-section write data |
| dq_out | output | DQ_W | Registered read data, or the compare result in test mode |

## Verification
The assertions assume that the strobes and test_mode are stable across each rising edge and are known once reset is released. They also assume that sec_rd shows the array contents for the read being sampled. The bench drives every input on the falling edge only, so each value is settled a half period before it is sampled. It sweeps both modes, both group selects, all sixteen DQ patterns, all 256 section patterns and all four strobe combinations, which covers every equal-versus-mismatch case and every read-modify-write pairing.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_TEST   = 1'b1
  } tmc_mode_e;
endpackage

// File: rtl/tmc_write_fanout.sv
module tmc_write_fanout
  import tmc_pkg::*;
#(
  parameter int DQ_W = 4,
  parameter int GRP  = 2,
  parameter int GSEL_W = $clog2(GRP)
) (
  input  tmc_mode_e               mode,
  input  logic                    wr_strobe,
  input  logic [GSEL_W-1:0]       col_lsb,
  input  logic [DQ_W-1:0]         dq_in,
  output logic [DQ_W*GRP-1:0]     sec_we,
  output logic [DQ_W*GRP-1:0]     sec_wd
);
  localparam int NSEC = DQ_W * GRP;

  logic in_test;
  assign in_test = (mode == MODE_TEST);

  for (genvar g = 0; g < GRP; g++) begin : g_grp
    logic grp_hit;
    assign grp_hit = in_test | (col_lsb == GSEL_W'(g));
    for (genvar k = 0; k < DQ_W; k++) begin : g_lane
      assign sec_wd[g*DQ_W + k] = in_test ? dq_in[0] : dq_in[k];
      assign sec_we[g*DQ_W + k] = wr_strobe & grp_hit;
    end
  end

  // Guards on the fan-out
  always_comb begin
    if (in_test && wr_strobe) begin
      p_all_sections_r1: assert (sec_we == {NSEC{1'b1}});
    end
    if (in_test) begin
      p_lane0_only_r2: assert (sec_wd == {NSEC{dq_in[0]}});
    end
    if (!wr_strobe) begin
      p_no_write_r8: assert (sec_we == '0);
    end
    if (!in_test) begin
      p_one_group_r6: assert ($countones(sec_we) == 0 || $countones(sec_we) == DQ_W);
    end
  end
endmodule

// File: rtl/tmc_read_compress.sv
module tmc_read_compress
  import tmc_pkg::*;
#(
  parameter int DQ_W = 4,
  parameter int GRP  = 2,
  parameter int GSEL_W = $clog2(GRP)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  tmc_mode_e               mode,
  input  logic                    rd_strobe,
  input  logic [GSEL_W-1:0]       col_lsb,
  input  logic [DQ_W*GRP-1:0]     sec_rd,
  output logic [DQ_W-1:0]         dq_out
);
  localparam int NSEC = DQ_W * GRP;

  logic [DQ_W-1:0] lane_bits;
  logic            agree;
  logic [DQ_W-1:0] next_dq;

  always_comb begin
    lane_bits = sec_rd[col_lsb*DQ_W +: DQ_W];
    agree     = (sec_rd == {NSEC{1'b0}}) || (sec_rd == {NSEC{1'b1}});
    next_dq   = (mode == MODE_TEST) ? {DQ_W{agree}} : lane_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
    end else if (rd_strobe) begin
      dq_out <= next_dq;
    end
  end

  p_pass_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && mode == MODE_TEST && (&sec_rd || !(|sec_rd))) |=> (&dq_out));

  p_fail_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && mode == MODE_TEST && !(&sec_rd) && (|sec_rd)) |=> (dq_out == '0));

  p_uniform_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && mode == MODE_TEST) |=> (dq_out == '0 || &dq_out));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(dq_out));
endmodule

// File: rtl/tmc_compare_path.sv
module tmc_compare_path
  import tmc_pkg::*;
#(
  parameter int DQ_W = 4,
  parameter int GRP  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    test_mode,
  input  logic                    wr_strobe,
  input  logic                    rd_strobe,
  input  logic [$clog2(GRP)-1:0]  col_lsb,
  input  logic [DQ_W-1:0]         dq_in,
  input  logic [DQ_W*GRP-1:0]     sec_rd,
  output logic [DQ_W*GRP-1:0]     sec_we,
  output logic [DQ_W*GRP-1:0]     sec_wd,
  output logic [DQ_W-1:0]         dq_out
);
  localparam int GSEL_W = $clog2(GRP);

  tmc_mode_e mode;
  assign mode = tmc_mode_e'(test_mode);

  tmc_write_fanout #(.DQ_W(DQ_W), .GRP(GRP), .GSEL_W(GSEL_W)) u_wr (
    .mode      (mode),
    .wr_strobe (wr_strobe),
    .col_lsb   (col_lsb),
    .dq_in     (dq_in),
    .sec_we    (sec_we),
    .sec_wd    (sec_wd)
  );

  tmc_read_compress #(.DQ_W(DQ_W), .GRP(GRP), .GSEL_W(GSEL_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .rd_strobe (rd_strobe),
    .col_lsb   (col_lsb),
    .sec_rd    (sec_rd),
    .dq_out    (dq_out)
  );

  // Read-modify-write: write enables must not depend on the read strobe
  p_rmw_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && wr_strobe) |-> (sec_we != '0));
endmodule

// File: tb/tmc_compare_path_tb.sv
module tmc_compare_path_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       test_mode = 1'b0;
  logic       wr_strobe = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [0:0] col_lsb = 1'b0;
  logic [3:0] dq_in = '0;
  logic [7:0] sec_rd = '0;
  logic [7:0] sec_we;
  logic [7:0] sec_wd;
  logic [3:0] dq_out;

  int errors = 0;
  int checks = 0;
  logic [3:0] exp_dq = 4'h0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmc_compare_path u_dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .wr_strobe(wr_strobe),
    .rd_strobe(rd_strobe), .col_lsb(col_lsb), .dq_in(dq_in), .sec_rd(sec_rd),
    .sec_we(sec_we), .sec_wd(sec_wd), .dq_out(dq_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(190000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dq_out == 4'h0, "R10 reset dq_out", {4'h0, dq_out}, 8'h00);
    chk(sec_we == 8'h00, "R8 reset no write", sec_we, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dq_out == 4'h0, "R10 after reset", {4'h0, dq_out}, 8'h00);

    for (int tm = 0; tm < 2; tm++) begin
      for (int c = 0; c < 2; c++) begin
        for (int d = 0; d < 16; d++) begin
          for (int s = 0; s < 256; s++) begin
            for (int rw = 0; rw < 4; rw++) begin
              logic [7:0] ewe, ewd;
              logic [3:0] nrd;
              @(negedge clk);
              // result of previous cycle's read (or held value)
              chk(dq_out == exp_dq,
                  tm == 1 ? "R3/R4/R5/R9 test read" : "R7/R9 normal read",
                  {4'h0, dq_out}, {4'h0, exp_dq});
              test_mode = tm[0];
              col_lsb   = c[0];
              dq_in     = d[3:0];
              sec_rd    = s[7:0];
              wr_strobe = rw[0];
              rd_strobe = rw[1];
              #1;
              if (tm == 1) begin
                ewe = rw[0] ? 8'hFF : 8'h00;
                ewd = d[0] ? 8'hFF : 8'h00;
                nrd = (s == 0 || s == 255) ? 4'hF : 4'h0;
              end else begin
                ewe = rw[0] ? (8'h0F << (4 * c)) : 8'h00;
                ewd = {d[3:0], d[3:0]};
                nrd = 4'((s >> (4 * c)) & 15);
              end
              chk(sec_we == ewe,
                  tm == 1 ? "R1/R5/R8/R11 test enables" : "R6/R8/R11 normal enables",
                  sec_we, ewe);
              chk(sec_wd == ewd,
                  tm == 1 ? "R1/R2 test data" : "R6 normal data",
                  sec_wd, ewd);
              if (rw[1]) exp_dq = nrd;
            end
          end
        end
      end
    end
    @(negedge clk);
    chk(dq_out == exp_dq, "R9 final", {4'h0, dq_out}, {4'h0, exp_dq});
    rst_n = 1'b0;
    #1;
    chk(dq_out == 4'h0, "R10 async reset", {4'h0, dq_out}, 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule